// File: doc/BRIEF.md
# Cartridge Bank and Flash-Write Controller

This block sits between an 8-bit cartridge bus that sees an 8K memory window and a 512K byte-wide flash device. It keeps an 8-bit bank/mode register. A write to the window loads that register from the address lines, not from the data lines. The flash address is formed by putting the 6 bank bits above the 13-bit window offset. The block also drives the flash chip-enable, output-enable and write-enable so that only intended bus cycles reach the device.

The top two register bits form a one-shot mode field. In read mode, a window write simply reloads the register. With a non-zero mode, exactly one qualifying write is sent to the flash, either as a command byte or as a program byte on one chosen byte lane. The mode then falls back to read and the bank is kept. Reads that happen while a write is pending, such as the read that a byte-move instruction performs before it writes, do not touch the pending mode. Writes on the wrong byte lane of a word store are masked.

Each clock cycle with the window selected is one bus cycle. The data-in direction input tells whether that cycle is a read (high) or a write (low). The strobes are combinational on the current cycle, and the register updates at the end of the cycle.

Top module: `cart_flash_bank`

## Requirements
- R1: Reset (active-low `rstN`) clears the register, so the bank is 0 and the mode is read.
- R2: A write in read mode loads the register from `busAddr[8:1]`, and `busAddr[0]` is ignored. The register's bit 7 is M0, bit 6 is M1 and bits 5..0 are the bank. For example, offsets 0x000, 0x006 and 0x1FE/0x1FF give 0x00, 0x03 and 0xFF.
- R3: The mode code {M0,M1} means 00 read, 01 command (the next write on either lane is forwarded), 10 program even lane and 11 program odd lane.
- R4: While the window is selected, `flashAddr` equals {bank[5:0], busAddr[12:0]}. For example, bank 2 with offset 0x1555 gives 0x05555.
- R5: In read mode, a window write never drives `flashWeN` low.
- R6: With a non-zero mode, a qualifying write drives `flashWeN` low and does not load the register. At the end of that cycle both mode bits clear and the bank bits are kept.
- R7: In mode 10 only even-lane writes (busAddr[0]=0) are forwarded, and in mode 11 only odd-lane writes (busAddr[0]=1). A write on the other lane drives no strobe low except chip-enable, and it leaves the mode and bank unchanged.
- R8: `flashOeN` is low only on a selected cycle with `dataIn` high, and never together with `flashWeN` low.
- R9: A read cycle while a mode is pending leaves the mode and bank unchanged, so the next qualifying write is still forwarded.
- R10: `flashCeN` is low exactly on selected cycles. A cycle with the window deselected keeps all strobes high and leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bus cycle per clock |
| rstN | input | 1 | Asynchronous active-low reset |
| winSel | input | 1 | Cartridge window selected in this cycle |
| dataIn | input | 1 | Bus direction: 1 read cycle, 0 write cycle |
| busAddr | input | 13 | Byte offset within the 8K window |
| flashAddr | output | 19 | Flash byte address {bank, offset} |
| flashCeN | output | 1 | Flash chip-enable, active low |
| flashOeN | output | 1 | Flash output-enable, active low |
| flashWeN | output | 1 | Flash write-enable, active low |

## Verification
The hardest state to reach from the ports is a pending program mode that then meets, in turn, a read-before-write, a write on the wrong lane and finally the matching-lane write. All three cycles must leave the mode intact until the last one. Directed sequences build exactly that order for both program lanes. They also replay a three-step unlock sequence, with each flash write preceded by a command-mode register load for bank 2, 1 and then 2. Seeded random cycles then mix selected and deselected reads and writes at random offsets. Because the offset bits pick the next mode, the random stream keeps entering command and program modes and meeting masked and pending cases that the directed tests do not list.

// File: rtl/cart_flash_pkg.sv
package cart_flash_pkg;

  // One-shot mode field, coded {M0,M1}
  typedef enum logic [1:0] {
    MODE_READ     = 2'b00,
    MODE_CMD      = 2'b01,
    MODE_PGM_EVEN = 2'b10,
    MODE_PGM_ODD  = 2'b11
  } flashMode_e;

  // Strobes from control to datapath and pins
  typedef struct packed {
    logic chipSel;
    logic flashRead;
    logic flashWrite;
    logic loadReg;
  } ctrlStrobes_t;

endpackage

// File: rtl/cart_flash_ctrl.sv
module cart_flash_ctrl
  import cart_flash_pkg::*;
(
  input  logic         winSel,
  input  logic         dataIn,
  input  logic         laneOdd,
  input  flashMode_e   curMode,
  output ctrlStrobes_t strb
);

  logic isWrite;
  logic laneOk;

  always_comb begin
    isWrite = winSel & ~dataIn;
    unique case (curMode)
      MODE_CMD:      laneOk = 1'b1;
      MODE_PGM_EVEN: laneOk = ~laneOdd;
      MODE_PGM_ODD:  laneOk = laneOdd;
      default:       laneOk = 1'b0;
    endcase
    strb.chipSel    = winSel;
    strb.flashRead  = winSel & dataIn;
    // Register load and flash write are mutually exclusive by mode
    strb.loadReg    = isWrite & (curMode == MODE_READ);
    strb.flashWrite = isWrite & (curMode != MODE_READ) & laneOk;
  end

endmodule

// File: rtl/cart_flash_dp.sv
module cart_flash_dp
  import cart_flash_pkg::*;
#(
  parameter int BANK_BITS   = 6,
  parameter int OFFSET_BITS = 13
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [OFFSET_BITS-1:0]         busAddr,
  input  ctrlStrobes_t                   strb,
  output flashMode_e                     curMode,
  output logic [BANK_BITS+1:0]           regOut,
  output logic [BANK_BITS+OFFSET_BITS-1:0] flashAddr
);

  localparam int REG_W = BANK_BITS + 2;

  logic [REG_W-1:0] bankReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankReg <= '0;
    end else if (strb.loadReg) begin
      // Address bit 0 is the byte lane and is not latched
      bankReg <= busAddr[REG_W:1];
    end else if (strb.flashWrite) begin
      bankReg[REG_W-1 -: 2] <= 2'b00;
    end
  end

  assign curMode   = flashMode_e'(bankReg[REG_W-1 -: 2]);
  assign regOut    = bankReg;
  assign flashAddr = {bankReg[BANK_BITS-1:0], busAddr};

endmodule

// File: rtl/cart_flash_bank.sv
module cart_flash_bank
  import cart_flash_pkg::*;
#(
  parameter int BANK_BITS   = 6,
  parameter int OFFSET_BITS = 13
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             winSel,
  input  logic                             dataIn,
  input  logic [OFFSET_BITS-1:0]           busAddr,
  output logic [BANK_BITS+OFFSET_BITS-1:0] flashAddr,
  output logic                             flashCeN,
  output logic                             flashOeN,
  output logic                             flashWeN
);

  ctrlStrobes_t         strb;
  flashMode_e           curMode;
  logic [BANK_BITS+1:0] regView;

  cart_flash_ctrl u_ctrl (
    .winSel  (winSel),
    .dataIn  (dataIn),
    .laneOdd (busAddr[0]),
    .curMode (curMode),
    .strb    (strb)
  );

  cart_flash_dp #(
    .BANK_BITS   (BANK_BITS),
    .OFFSET_BITS (OFFSET_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .strb      (strb),
    .curMode   (curMode),
    .regOut    (regView),
    .flashAddr (flashAddr)
  );

  assign flashCeN = ~strb.chipSel;
  assign flashOeN = ~strb.flashRead;
  assign flashWeN = ~strb.flashWrite;

endmodule

// File: rtl/cart_flash_bank_chk.sv
module cart_flash_bank_chk #(
  parameter int BANK_BITS   = 6,
  parameter int OFFSET_BITS = 13
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   winSel,
  input logic                   dataIn,
  input logic [OFFSET_BITS-1:0] busAddr,
  input logic                   flashCeN,
  input logic                   flashOeN,
  input logic                   flashWeN,
  input logic [BANK_BITS+1:0]   regVal
);

  localparam int REG_W = BANK_BITS + 2;

  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> regVal == '0);

  p_load_from_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (winSel && !dataIn && regVal[REG_W-1 -: 2] == 2'b00)
      |=> regVal == $past(busAddr[REG_W:1]));

  p_read_mode_no_we_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regVal[REG_W-1 -: 2] == 2'b00) |-> flashWeN);

  p_we_clears_mode_r6: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |=> (regVal[REG_W-1 -: 2] == 2'b00) &&
                  (regVal[BANK_BITS-1:0] == $past(regVal[BANK_BITS-1:0])));

  p_lane_match_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!flashWeN && regVal[REG_W-1]) |-> (busAddr[0] == regVal[REG_W-2]));

  p_oe_read_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    !flashOeN |-> (winSel && dataIn && flashWeN));

  p_read_keeps_reg_r9: assert property (@(posedge clk) disable iff (!rstN)
    (winSel && dataIn) |=> $stable(regVal));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !winSel |-> (flashCeN && flashOeN && flashWeN));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !winSel |=> $stable(regVal));

endmodule

bind cart_flash_bank cart_flash_bank_chk #(
  .BANK_BITS   (BANK_BITS),
  .OFFSET_BITS (OFFSET_BITS)
) chk (
  .clk      (clk),
  .rstN     (rstN),
  .winSel   (winSel),
  .dataIn   (dataIn),
  .busAddr  (busAddr),
  .flashCeN (flashCeN),
  .flashOeN (flashOeN),
  .flashWeN (flashWeN),
  .regVal   (regView)
);

// File: tb/cart_flash_bank_test.sv
module cart_flash_bank_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        winSel = 1'b0;
  logic        dataIn = 1'b1;
  logic [12:0] busAddr = '0;
  logic [18:0] flashAddr;
  logic        flashCeN, flashOeN, flashWeN;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] expReg = 8'h00;

  always #5 clk = ~clk;

  cart_flash_bank uut (
    .clk(clk), .rstN(rstN), .winSel(winSel), .dataIn(dataIn),
    .busAddr(busAddr), .flashAddr(flashAddr),
    .flashCeN(flashCeN), .flashOeN(flashOeN), .flashWeN(flashWeN)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic laneOkFn(input logic [1:0] m, input logic odd);
    case (m)
      2'b01:   return 1'b1;
      2'b10:   return !odd;
      2'b11:   return odd;
      default: return 1'b0;
    endcase
  endfunction

  // One bus cycle: drive, check combinational outputs, update model
  task automatic cyc(input logic sel, input logic rd, input logic [12:0] a);
    logic [1:0] m;
    logic isW, fwd;
    string weTag, oeTag;
    @(negedge clk);
    winSel = sel; dataIn = rd; busAddr = a;
    #2;
    m   = expReg[7:6];
    isW = sel && !rd;
    fwd = isW && (m != 2'b00) && laneOkFn(m, a[0]);
    weTag = (m == 2'b00) ? "R5" : (laneOkFn(m, a[0]) ? "R6" : "R7");
    oeTag = (rd && m != 2'b00) ? "R9" : "R8";
    chk("R10", 32'(flashCeN), 32'(!sel));
    chk(oeTag, 32'(flashOeN), 32'(!(sel && rd)));
    chk(weTag, 32'(flashWeN), 32'(!fwd));
    if (sel) chk("R4", 32'(flashAddr), 32'({expReg[5:0], a}));
    if (isW && m == 2'b00) expReg = a[8:1];
    else if (fwd) expReg[7:6] = 2'b00;
  endtask

  task automatic doReset();
    @(negedge clk);
    winSel = 1'b0; dataIn = 1'b1; rstN = 1'b0;
    expReg = 8'h00;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C1A));
    doReset();

    // R1: reset state, bank 0 and read mode
    cyc(1, 1, 13'h1ABC);
    chk("R1", 32'(flashAddr[18:13]), 32'h0);
    cyc(1, 0, 13'h1000);                  // offset bits 8:1 = 0 -> stays read
    chk("R1", 32'(flashWeN), 32'h1);

    // R2: register load examples
    cyc(1, 0, 13'h1FF);                   // bit 0 ignored -> 0xFF
    cyc(1, 1, 13'h0000);
    chk("R2", 32'(flashAddr), 32'({6'h3F, 13'h0}));
    cyc(1, 0, 13'h0000);                  // mode 11, even lane masked
    chk("R7", 32'(flashWeN), 32'h1);
    cyc(1, 0, 13'h0001);                  // odd lane forwarded
    chk("R3", 32'(flashWeN), 32'h0);
    cyc(1, 0, 13'h0006);
    cyc(1, 1, 13'h0000);
    chk("R2", 32'(flashAddr), 32'({6'h03, 13'h0}));
    cyc(1, 0, 13'h0000);
    cyc(1, 1, 13'h0100);
    chk("R2", 32'(flashAddr), 32'h100);

    // R6/R4: unlock sequence, command mode with bank 2, 1, 2
    cyc(1, 0, 13'h0084);
    cyc(1, 0, 13'h1555);
    chk("R6", 32'(flashAddr), 32'h05555);
    chk("R6", 32'(flashWeN), 32'h0);
    cyc(1, 0, 13'h0082);
    cyc(1, 0, 13'h0AAA);
    chk("R6", 32'(flashAddr), 32'h02AAA);
    chk("R6", 32'(flashWeN), 32'h0);
    cyc(1, 0, 13'h0084);
    cyc(1, 0, 13'h1555);
    chk("R6", 32'(flashAddr), 32'h05555);
    chk("R6", 32'(flashWeN), 32'h0);

    // R3: command mode forwards an even-lane write too
    cyc(1, 0, 13'h0080);
    cyc(1, 0, 13'h0002);
    chk("R3", 32'(flashWeN), 32'h0);

    // R9/R7: program even, read-before-write, odd masked, even forwarded
    cyc(1, 0, 13'h0104);
    cyc(1, 1, 13'h0010);
    chk("R9", 32'(flashOeN), 32'h0);
    chk("R9", 32'(flashWeN), 32'h1);
    cyc(1, 0, 13'h0011);
    chk("R7", 32'(flashWeN), 32'h1);
    cyc(0, 0, 13'h0010);                  // deselected write changes nothing
    chk("R10", 32'({flashCeN, flashOeN, flashWeN}), 32'h7);
    cyc(1, 0, 13'h0010);
    chk("R7", 32'(flashWeN), 32'h0);
    chk("R7", 32'(flashAddr), 32'h04010);
    cyc(1, 1, 13'h0000);
    chk("R6", 32'(flashAddr), 32'h04000);  // bank kept, mode cleared
    cyc(1, 0, 13'h0020);
    chk("R6", 32'(flashWeN), 32'h1);

    // Program odd with read-before-write
    cyc(1, 0, 13'h0186);
    cyc(1, 1, 13'h0201);
    cyc(1, 0, 13'h0200);
    chk("R7", 32'(flashWeN), 32'h1);
    cyc(1, 0, 13'h0201);
    chk("R9", 32'(flashWeN), 32'h0);
    chk("R4", 32'(flashAddr), 32'({6'h03, 13'h0201}));

    // Seeded random mix
    for (int i = 0; i < 4000; i++) begin
      logic sel, rd;
      sel = ($urandom % 10) < 8;
      rd  = ($urandom % 10) < 4;
      cyc(sel, rd, 13'($urandom));
    end

    // Reset in the middle of a pending mode
    cyc(1, 0, 13'h01FE);
    doReset();
    cyc(1, 1, 13'h0ABC);
    chk("R1", 32'(flashAddr), 32'h00ABC);
    cyc(1, 0, 13'h0001);
    chk("R1", 32'(flashWeN), 32'h1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule